// File: doc/BRIEF.md
# FSM State Debug Encoder

This block watches the one-hot state register of a finite state machine and turns it into a compact binary state code. The code can feed a status register or an on-chip logic analyzer. The one-hot vector is first copied into a private register, so the encoder loads nothing but that copy. The copy is encoded to a 4-bit code equal to the bit position of the single set bit. Any pattern without exactly one bit set, whether all zeros or several ones, maps to a reserved code with an illegal flag. The all-zero pattern therefore never looks like the idle state.

The observer lives in a second clock domain and asks for a snapshot with a one-cycle capture request. The request travels as a toggle through a two-flop synchronizer into the source domain. There the current code and flag are frozen in a hold register, and an acknowledge toggle is sent back through another two-flop synchronizer. When that acknowledge arrives, the destination domain copies the now-stable hold register to its outputs and raises a one-cycle valid strobe. Every bit of a delivered code therefore comes from the same source cycle.

The output side is a stream with a valid strobe and no ready. The observer cannot apply back-pressure, so it must take each snapshot in the cycle its strobe is high. The outputs keep their value until the next completed capture. A request made while an earlier one is still in flight is dropped.

Top module: `fsm_state_tap`

## Requirements
- R1: A state vector with exactly one bit set at position i (0 = idle, up to N_STATES-1, where N_STATES is at most 15) is delivered as code_out = i with illegal_out low.
- R2: An all-zero state vector is delivered as code_out = 4'hF with illegal_out high, and never as code 0.
- R3: A state vector with two or more bits set is delivered as code_out = 4'hF with illegal_out high.
- R4: illegal_out is high in exactly those destination cycles in which code_out equals 4'hF.
- R5: Each accepted capture request produces exactly one valid_out pulse, one destination cycle wide, within 40 destination cycles. code_out and illegal_out carry the snapshot in the cycle of that pulse.
- R6: All bits of a delivered code come from one source cycle: a state vector held stable across the capture is reproduced exactly.
- R7: A capture request raised while an earlier request has not yet produced its valid pulse is ignored and yields no extra pulse.
- R8: After reset, code_out reads 4'hF, illegal_out is high and valid_out is low, and no valid pulse appears until a capture request completes.
- R9: Between valid pulses, code_out and illegal_out hold their value even when the state vector changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Clock of the observed state machine |
| dst_clk | input | 1 | Clock of the observer |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| state_onehot | input | N_STATES | One-hot state vector of the observed machine |
| cap_req | input | 1 | One-cycle snapshot request, destination domain |
| code_out | output | 4 | Binary state code, 4'hF when the pattern is illegal |
| illegal_out | output | 1 | High when the snapshot held no valid one-hot pattern |
| valid_out | output | 1 | One-cycle strobe marking a new snapshot |

## Verification
A wrong encoder state appears at the ports as a wrong code or flag at the next valid pulse. This includes a zero-hot vector aliased to idle, or a multi-hot vector reported as a legal state. A stuck or doubled handshake toggle shows up within about 40 destination cycles of a request, either as a missing strobe or as a second strobe. A hold register that moves between captures shows as code_out changing with no strobe. The bench checks for this while the state vector keeps changing.

// File: rtl/ftap_pkg.sv
package ftap_pkg;
  localparam int CODE_W = 4;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t BAD_CODE = '1;
endpackage

// File: rtl/ftap_sync.sv
module ftap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ftap_encoder.sv
module ftap_encoder
  import ftap_pkg::*;
#(
  parameter int N_STATES = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_STATES-1:0] state_i,
  output code_t               code_o,
  output logic                bad_o
);
  logic [N_STATES-1:0] copy_q;
  code_t               idx;
  int unsigned         ones;

  always_comb begin
    idx  = '0;
    ones = $countones(copy_q);
    for (int i = 0; i < N_STATES; i++) begin
      if (copy_q[i]) idx = code_t'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      copy_q <= '0;
      code_o <= BAD_CODE;
      bad_o  <= 1'b1;
    end else begin
      copy_q <= state_i;
      code_o <= (ones == 1) ? idx : BAD_CODE;
      bad_o  <= (ones != 1);
    end
  end

  // R1
  idle_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_q == N_STATES'(1)) |=> (code_o == '0 && !bad_o));
  // R2
  zero_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_q == '0) |=> (code_o != '0 && bad_o));
  // R3
  multi_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(copy_q) > 1) |=> (code_o == BAD_CODE && bad_o));
endmodule

// File: rtl/ftap_src_hold.sv
module ftap_src_hold
  import ftap_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_tgl_i,
  input  code_t code_i,
  input  logic  bad_i,
  output code_t hold_code_o,
  output logic  hold_bad_o,
  output logic  ack_tgl_o
);
  logic req_s, req_d, req_edge;

  ftap_sync #(.STAGES(2)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req_tgl_i), .q(req_s)
  );

  assign req_edge = req_s ^ req_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d       <= 1'b0;
      hold_code_o <= BAD_CODE;
      hold_bad_o  <= 1'b1;
      ack_tgl_o   <= 1'b0;
    end else begin
      req_d <= req_s;
      if (req_edge) begin
        hold_code_o <= code_i;
        hold_bad_o  <= bad_i;
        ack_tgl_o   <= ~ack_tgl_o;
      end
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_edge |=> ($stable(hold_code_o) && $stable(ack_tgl_o)));
endmodule

// File: rtl/fsm_state_tap.sv
module fsm_state_tap
  import ftap_pkg::*;
#(
  parameter int N_STATES = 11
) (
  input  logic                src_clk,
  input  logic                dst_clk,
  input  logic                rst_n,
  input  logic [N_STATES-1:0] state_onehot,
  input  logic                cap_req,
  output logic [CODE_W-1:0]   code_out,
  output logic                illegal_out,
  output logic                valid_out
);
  code_t enc_code, hold_code;
  logic  enc_bad, hold_bad, ack_tgl;
  logic  req_tgl, ack_s, ack_d, ack_edge, busy;

  ftap_encoder #(.N_STATES(N_STATES)) u_enc (
    .clk(src_clk), .rst_n(rst_n), .state_i(state_onehot),
    .code_o(enc_code), .bad_o(enc_bad)
  );

  ftap_src_hold u_hold (
    .clk(src_clk), .rst_n(rst_n), .req_tgl_i(req_tgl),
    .code_i(enc_code), .bad_i(enc_bad),
    .hold_code_o(hold_code), .hold_bad_o(hold_bad), .ack_tgl_o(ack_tgl)
  );

  ftap_sync #(.STAGES(2)) u_ack_sync (
    .clk(dst_clk), .rst_n(rst_n), .d(ack_tgl), .q(ack_s)
  );

  assign ack_edge = ack_s ^ ack_d;
  assign busy     = req_tgl ^ ack_d;

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl     <= 1'b0;
      ack_d       <= 1'b0;
      code_out    <= BAD_CODE;
      illegal_out <= 1'b1;
      valid_out   <= 1'b0;
    end else begin
      ack_d     <= ack_s;
      valid_out <= ack_edge;
      if (cap_req && !busy) req_tgl <= ~req_tgl;
      if (ack_edge) begin
        code_out    <= hold_code;
        illegal_out <= hold_bad;
      end
    end
  end

  // R4
  illegal_flag_chk: assert property (@(posedge dst_clk) disable iff (!rst_n)
    illegal_out == (code_out == BAD_CODE));
  // R5
  valid_pulse_chk: assert property (@(posedge dst_clk) disable iff (!rst_n)
    valid_out |=> !valid_out);
  // R7
  drop_req_chk: assert property (@(posedge dst_clk) disable iff (!rst_n)
    (busy && cap_req) |=> $stable(req_tgl));
  // R9
  out_hold_chk: assert property (@(posedge dst_clk) disable iff (!rst_n)
    !valid_out |=> ($stable(code_out) || valid_out));
endmodule

// File: tb/fsm_state_tap_bench.sv
`timescale 1ns/1ps
module fsm_state_tap_bench;
  localparam int N = 11;

  logic src_clk = 1'b0, dst_clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] state_onehot = '0;
  logic cap_req = 1'b0;
  logic [3:0] code_out;
  logic illegal_out, valid_out;
  int checks = 0, fails = 0;

  always #2 src_clk = ~src_clk;
  always #3.5 dst_clk = ~dst_clk;

  fsm_state_tap #(.N_STATES(N)) u_fsm_state_tap (
    .src_clk(src_clk), .dst_clk(dst_clk), .rst_n(rst_n),
    .state_onehot(state_onehot), .cap_req(cap_req),
    .code_out(code_out), .illegal_out(illegal_out), .valid_out(valid_out)
  );

  function automatic logic [3:0] ref_code(input logic [N-1:0] v);
    int cnt = 0;
    logic [3:0] idx = '0;
    for (int i = 0; i < N; i++) if (v[i]) begin cnt++; idx = 4'(i); end
    return (cnt == 1) ? idx : 4'hF;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
  endtask

  task automatic capture(input logic [N-1:0] v, input string tag);
    logic [3:0] exp;
    bit seen = 0;
    exp = ref_code(v);
    state_onehot = v;
    repeat (4) @(posedge src_clk);
    @(negedge dst_clk) cap_req = 1'b1;
    @(negedge dst_clk) cap_req = 1'b0;
    for (int k = 0; k < 40 && !seen; k++) begin
      @(negedge dst_clk);
      if (valid_out) seen = 1;
    end
    check({tag, " R5 valid seen"}, 32'(seen), 32'd1);
    check({tag, " R1/R2/R3/R6 code"}, 32'(code_out), 32'(exp));
    check({tag, " R4 flag"}, 32'(illegal_out), 32'(exp == 4'hF));
    @(negedge dst_clk);
    check({tag, " R5 one-cycle strobe"}, 32'(valid_out), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge src_clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    int pulses;
    logic [N-1:0] v;
    logic [3:0] keep;
    void'($urandom(32'd1234));
    repeat (5) @(negedge dst_clk);
    rst_n = 1'b1;
    // R8: reset state and silence
    @(negedge dst_clk);
    check("R8 code after reset", 32'(code_out), 32'hF);
    check("R8 flag after reset", 32'(illegal_out), 32'd1);
    pulses = 0;
    state_onehot = N'(4);
    for (int k = 0; k < 30; k++) begin @(negedge dst_clk); if (valid_out) pulses++; end
    check("R8 no strobe before capture", 32'(pulses), 32'd0);

    // R1: every legal state
    for (int i = 0; i < N; i++) capture(N'(1) << i, "R1 legal");
    // R2: zero-hot
    capture('0, "R2 zero-hot");
    // R3: multi-hot
    capture(N'(3), "R3 two-hot");
    capture('1, "R3 all-hot");
    capture(N'(1) | (N'(1) << (N-1)), "R3 ends-hot");

    // R7: second request while busy is dropped
    state_onehot = N'(32);
    repeat (4) @(posedge src_clk);
    @(negedge dst_clk) cap_req = 1'b1;
    @(negedge dst_clk) cap_req = 1'b0;
    @(negedge dst_clk) cap_req = 1'b1;
    @(negedge dst_clk) cap_req = 1'b0;
    pulses = 0;
    for (int k = 0; k < 60; k++) begin @(negedge dst_clk); if (valid_out) pulses++; end
    check("R7 single pulse for overlapped requests", 32'(pulses), 32'd1);
    check("R7 code", 32'(code_out), 32'd5);

    // R9: outputs hold while the state vector moves
    keep = code_out;
    pulses = 0;
    for (int k = 0; k < 40; k++) begin
      state_onehot = N'($urandom);
      @(negedge dst_clk);
      if (valid_out) pulses++;
    end
    check("R9 code held", 32'(code_out), 32'(keep));
    check("R9 no strobe", 32'(pulses), 32'd0);

    // Random mix, R6 coherence
    for (int it = 0; it < 40; it++) begin
      if ($urandom % 4 != 0) v = N'(1) << ($urandom % N);
      else                   v = N'($urandom);
      capture(v, "R6 random");
    end

    summary();
    $finish;
  end
endmodule